// File: doc/BRIEF.md
# Buffered-Transmit SPI Master

This block is an SPI master that software drives through four word-wide registers on a simple memory-mapped port. A transmit word goes first into a one-entry holding register. It then moves into the shift register as soon as the shifter is free. Software can therefore queue the next word while the current one is still on the wire. Each received word lands in a receive data register. A status register reports these conditions:

- transmit-ready
- receive-ready
- shifter-empty
- two sticky overrun flags
- their combined error bit

A control register holds one interrupt enable per status bit. The interrupt output is high whenever any enabled status bit is set.

The serial side uses one fixed format:

- clock idles low
- data changes on the falling edge and is sampled on the rising edge
- most significant bit first
- `DATA_W` bits per transfer
- each clock half-period lasts `CLK_DIV` system cycles
- one active-low select, held low for the whole word

Reads return data in the same cycle, from the offset on `busAddr`. Reading the receive register consumes its word. Writing the status register clears the error flags.

Top module: `spi_buffered_master`

## Requirements
- R1: After reset, status reads 0x060 (shifter-empty at bit 5 and transmit-ready at bit 6 set, nothing else), control reads 0, `ssN` is 1, `sclk` is 0 and `irq` is 0.
- R2: Offsets are: receive data at 0 (zero-extended), transmit data at 1 (reads 0), status at 2 and control at 3. Status bits are: receive overrun bit 3, transmit overrun bit 4, shifter-empty bit 5, transmit-ready bit 6, receive-ready bit 7, error bit 8. All other status bits read 0.
- R3: An accepted write to offset 1 clears transmit-ready from the next cycle on. If the shifter is idle, the word moves into the shifter one cycle later. At that point transmit-ready returns to 1 and shifter-empty goes to 0.
- R4: A write to offset 1 while transmit-ready is 0 is discarded, and it sets the transmit overrun bit.
- R5: Each transfer behaves as follows:
  - `ssN` is low for the whole transfer.
  - There are exactly `DATA_W` rising edges of `sclk`.
  - `mosi` carries the word MSB first and is valid at each rising edge.
  - The received word is `miso` sampled at those rising edges, MSB first.
  - Outside a transfer, `ssN` is 1 and `sclk` is 0.
- R6: When a transfer completes, the received word is stored and receive-ready becomes 1. A read of offset 0 clears receive-ready. If a word completes in the same cycle as that read, the new word wins and receive-ready stays 1.
- R7: If a word completes while receive-ready is 1 and no read of offset 0 happens in that cycle, the new word overwrites the stored one and the receive overrun bit is set.
- R8: The status error bit always equals receive overrun OR transmit overrun.
- R9: Any write to offset 2 clears both overrun bits and the error bit, whatever the data. An overrun event in the same cycle as that write wins. Reading status changes no bit.
- R10: Only control bits 8 to 3 are writable; the rest read 0. `irq` is the OR over all bits of (status AND control).
- R11: A word written while the shifter is busy waits in the holding register. It starts shifting right after the current transfer completes. Words leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 2 | Register offset |
| busWrite | input | 1 | Write strobe, one cycle per access |
| busRead | input | 1 | Read strobe, one cycle per access |
| busWdata | input | BUS_W | Write data |
| busRdata | output | BUS_W | Read data for `busAddr`, same cycle |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssN | output | 1 | Active-low slave select |

## Verification
The properties assume that `busRead` and `busWrite` are never high together, and that each access lasts a single cycle. A read of status is taken as evidence only in the cycle it is issued. The bench drives every access from one task per direction. Each task raises exactly one strobe for exactly one cycle, so the assumption holds throughout. `miso` is tied to the inverse of `mosi`, so every received word is the complement of the transmitted one. The bench issues no access in the cycle a transfer completes, except through status polling, so no read-clear collides with a completion.

// File: rtl/spim_pkg.sv
package spim_pkg;

  // Register offsets on the bus
  localparam logic [1:0] ADDR_RX   = 2'd0;
  localparam logic [1:0] ADDR_TX   = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_CTRL = 2'd3;

  // Status / enable bit positions
  localparam int BIT_ROVR = 3;
  localparam int BIT_TOVR = 4;
  localparam int BIT_IDLE = 5;
  localparam int BIT_TRDY = 6;
  localparam int BIT_RRDY = 7;
  localparam int BIT_ERR  = 8;

  // Strobes from the register control to the shifting datapath
  typedef struct packed {
    logic holdWrite;   // load the holding register with the write data
  } ctrlStrobe_t;

  // Events and state reported by the datapath back to the control
  typedef struct packed {
    logic rxDone;      // one-cycle pulse: a word has finished shifting
    logic holdFull;    // holding register occupied
    logic shifterBusy; // a transfer is in progress
  } dpEvent_t;

endpackage

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic              irq,
  output ctrlStrobe_t       strobe,
  output logic [DATA_W-1:0] holdData,
  input  dpEvent_t          dpEvt,
  input  logic [DATA_W-1:0] rxWord,
  output logic [BUS_W-1:0]  statusVec
);

  localparam logic [BUS_W-1:0] CTRL_MASK = BUS_W'(9'h1F8);

  logic [DATA_W-1:0] rxReg;
  logic              rxFull;
  logic              rxOvr;
  logic              txOvr;
  logic [BUS_W-1:0]  ctrlReg;

  logic wrTx, wrStat, wrCtrl, rdRx;
  logic txAccept, txReject, rxOvrSet;

  always_comb begin
    wrTx     = busWrite && (busAddr == ADDR_TX);
    wrStat   = busWrite && (busAddr == ADDR_STAT);
    wrCtrl   = busWrite && (busAddr == ADDR_CTRL);
    rdRx     = busRead  && (busAddr == ADDR_RX);
    txAccept = wrTx && !dpEvt.holdFull;
    txReject = wrTx &&  dpEvt.holdFull;
    rxOvrSet = dpEvt.rxDone && rxFull && !rdRx;
  end

  always_comb begin
    strobe.holdWrite = txAccept;
    holdData         = busWdata[DATA_W-1:0];
  end

  // Sticky error flags: a set event outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxOvr <= 1'b0;
      txOvr <= 1'b0;
    end else begin
      rxOvr <= rxOvrSet || (rxOvr && !wrStat);
      txOvr <= txReject || (txOvr && !wrStat);
    end
  end

  // Receive register: a completing word beats a read-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg  <= '0;
      rxFull <= 1'b0;
    end else begin
      if (dpEvt.rxDone) begin
        rxReg  <= rxWord;
        rxFull <= 1'b1;
      end else if (rdRx) begin
        rxFull <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (wrCtrl) begin
      ctrlReg <= busWdata & CTRL_MASK;
    end
  end

  always_comb begin
    statusVec           = '0;
    statusVec[BIT_ROVR] = rxOvr;
    statusVec[BIT_TOVR] = txOvr;
    statusVec[BIT_IDLE] = !dpEvt.shifterBusy;
    statusVec[BIT_TRDY] = !dpEvt.holdFull;
    statusVec[BIT_RRDY] = rxFull;
    statusVec[BIT_ERR]  = rxOvr || txOvr;
  end

  logic [BUS_W-1:0] rxExt;
  always_comb begin
    rxExt               = '0;
    rxExt[DATA_W-1:0]   = rxReg;
  end

  always_comb begin
    unique case (busAddr)
      ADDR_RX:   busRdata = rxExt;
      ADDR_TX:   busRdata = '0;
      ADDR_STAT: busRdata = statusVec;
      default:   busRdata = ctrlReg;
    endcase
  end

  assign irq = |(statusVec & ctrlReg);

endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] holdData,
  output dpEvent_t          dpEvt,
  output logic [DATA_W-1:0] rxWord,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              ssN
);

  localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  logic [DATA_W-1:0] holdReg;
  logic              holdFull;
  logic              busy;
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic [CNT_W-1:0]  divCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              sclkReg;
  logic              doneReg;

  logic halfTick, startXfer;
  always_comb begin
    halfTick  = busy && (divCnt == CNT_LAST);
    startXfer = holdFull && !busy;
  end

  // Holding register: filled by the control strobe, drained into the shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
    end else if (startXfer) begin
      holdFull <= 1'b0;
    end else if (strobe.holdWrite) begin
      holdReg  <= holdData;
      holdFull <= 1'b1;
    end
  end

  // Shift engine: clock idles low, sample on rise, advance on fall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      txShift <= '0;
      rxShift <= '0;
      divCnt  <= '0;
      bitCnt  <= '0;
      sclkReg <= 1'b0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      if (startXfer) begin
        busy    <= 1'b1;
        txShift <= holdReg;
        divCnt  <= '0;
        bitCnt  <= '0;
        sclkReg <= 1'b0;
      end else if (busy) begin
        if (halfTick) begin
          divCnt <= '0;
          if (!sclkReg) begin
            sclkReg <= 1'b1;
            rxShift <= {rxShift[DATA_W-2:0], miso};
          end else begin
            sclkReg <= 1'b0;
            if (bitCnt == BIT_LAST) begin
              busy    <= 1'b0;
              doneReg <= 1'b1;
            end else begin
              bitCnt  <= bitCnt + 1'b1;
              txShift <= {txShift[DATA_W-2:0], 1'b0};
            end
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    dpEvt.rxDone      = doneReg;
    dpEvt.holdFull    = holdFull;
    dpEvt.shifterBusy = busy;
    rxWord            = rxShift;
    sclk              = sclkReg;
    mosi              = busy && txShift[DATA_W-1];
    ssN               = !busy;
  end

endmodule

// File: rtl/spi_buffered_master.sv
module spi_buffered_master
  import spim_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int BUS_W   = 16,
  parameter int CLK_DIV = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       busAddr,
  input  logic             busWrite,
  input  logic             busRead,
  input  logic [BUS_W-1:0] busWdata,
  output logic [BUS_W-1:0] busRdata,
  output logic             irq,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             ssN
);

  ctrlStrobe_t       strobe;
  dpEvent_t          dpEvt;
  logic [DATA_W-1:0] holdData;
  logic [DATA_W-1:0] rxWord;
  logic [BUS_W-1:0]  statusVec;

  spim_regs #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_regs (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrite(busWrite), .busRead(busRead),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq),
    .strobe(strobe), .holdData(holdData),
    .dpEvt(dpEvt), .rxWord(rxWord), .statusVec(statusVec)
  );

  spim_shift #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .holdData(holdData),
    .dpEvt(dpEvt), .rxWord(rxWord),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ssN(ssN)
  );

endmodule

// File: rtl/spim_checker.sv
module spim_checker (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  busAddr,
  input logic        busWrite,
  input logic        busRead,
  input logic [15:0] busRdata,
  input logic        ssN,
  input logic        sclk,
  input logic        holdFull,
  input logic        busy,
  input logic        rxDone,
  input logic        rrdy,
  input logic        roe,
  input logic        toe
);

  // R3: an accepted transmit write fills the holding register
  a_r3_hold_fill: assert property (@(posedge clk) disable iff (!rstN)
    busWrite && busAddr == 2'd1 && !holdFull |=> holdFull);

  // R3: an idle shifter takes the held word on the next edge
  a_r3_idle_load: assert property (@(posedge clk) disable iff (!rstN)
    holdFull && !busy |=> !holdFull && busy);

  // R4: a write while full raises the transmit overrun flag
  a_r4_toe_set: assert property (@(posedge clk) disable iff (!rstN)
    busWrite && busAddr == 2'd1 && holdFull |=> toe);

  // R5: lines rest when no transfer runs
  a_r5_idle_lines: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> ssN && !sclk);

  // R6: a finished word always leaves receive-ready set
  a_r6_rrdy_set: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> rrdy);

  // R7: completing onto an unread word flags an overrun
  a_r7_roe_set: assert property (@(posedge clk) disable iff (!rstN)
    rxDone && rrdy && !(busRead && busAddr == 2'd0) |=> roe);

  // R8: error bit seen on the bus equals the OR of the overruns
  a_r8_err_or: assert property (@(posedge clk) disable iff (!rstN)
    busRead && busAddr == 2'd2 |-> busRdata[8] == (busRdata[3] | busRdata[4]));

  // R9: a status write with no competing event clears both flags
  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    busWrite && busAddr == 2'd2 && !rxDone |=> !roe && !toe);

  // R9: reading status leaves the transmit overrun flag alone
  a_r9_read_stable: assert property (@(posedge clk) disable iff (!rstN)
    busRead && busAddr == 2'd2 && !busWrite |=> $stable(toe));

endmodule

bind spi_buffered_master spim_checker u_chk (
  .clk(clk), .rstN(rstN),
  .busAddr(busAddr), .busWrite(busWrite), .busRead(busRead),
  .busRdata(busRdata[15:0]), .ssN(ssN), .sclk(sclk),
  .holdFull(dpEvt.holdFull), .busy(dpEvt.shifterBusy),
  .rxDone(dpEvt.rxDone), .rrdy(statusVec[7]),
  .roe(statusVec[3]), .toe(statusVec[4])
);

// File: tb/spi_buffered_master_bench.sv
module spi_buffered_master_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busAddr = '0;
  logic        busWrite = 1'b0;
  logic        busRead = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        irq, sclk, mosi, ssN;
  logic        miso;

  assign miso = ~mosi;   // inverting loopback: received = ~sent

  always #5 clk = ~clk;

  spi_buffered_master u_spi_buffered_master (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busRead(busRead), .busWdata(busWdata), .busRdata(busRdata),
    .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .ssN(ssN)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] expQ[$];
  logic [7:0] lastRx;
  event       rxSeen;

  // Serial monitor: capture mosi at each rising sclk, snapshot at end of word
  int         riseCnt = 0;
  logic [7:0] mosiCap = '0;
  int         lastRises = 0;
  logic [7:0] lastMosi = '0;
  always @(posedge sclk) if (!ssN) begin
    riseCnt++;
    mosiCap = {mosiCap[6:0], mosi};
  end
  always @(posedge ssN) begin
    lastRises = riseCnt;
    lastMosi  = mosiCap;
    riseCnt   = 0;
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares every receive read against the queue
  initial forever begin
    @(rxSeen);
    if (expQ.size() == 0) check("R6 unexpected rx", {8'h0, lastRx}, 16'hDEAD);
    else check("R5/R6 rx word", {8'h0, lastRx}, {8'h0, expQ.pop_front()});
  end

  task automatic busWr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [1:0] a, output logic [15:0] d);
    busAddr = a; busRead = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRead = 1'b0;
  endtask

  // Driver: writes a word and pushes the expected loopback result if accepted
  task automatic sendWord(input logic [7:0] w, input bit accepted);
    busWr(2'd1, {8'h0, w});
    if (accepted) expQ.push_back(~w);
  endtask

  task automatic readRx();
    logic [15:0] d;
    busRd(2'd0, d);
    lastRx = d[7:0];
    ->rxSeen;
    #1;
  endtask

  task automatic waitStatus(input logic [15:0] mask, input string req);
    logic [15:0] s;
    for (int i = 0; i < 2000; i++) begin
      busRd(2'd2, s);
      if ((s & mask) == mask) return;
    end
    check(req, s & mask, mask);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] s, s2;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRd(2'd2, s); check("R1 status", s, 16'h0060);
    busRd(2'd3, s); check("R1 control", s, 16'h0000);
    check("R1 lines", {13'h0, ssN, sclk, irq}, 16'h0004);

    // R10 / R2 control mask and irq
    busWr(2'd3, 16'hFFFF);
    busRd(2'd3, s); check("R10 control mask", s, 16'h01F8);
    check("R10 irq on idle enables", {15'h0, irq}, 16'h0001);
    busRd(2'd1, s); check("R2 tx reads zero", s, 16'h0000);
    busWr(2'd3, 16'h0000);
    check("R10 irq off", {15'h0, irq}, 16'h0000);

    // R3 handoff timing
    sendWord(8'hA5, 1);
    busRd(2'd2, s); check("R3 held, trdy low", s, 16'h0020);
    busRd(2'd2, s); check("R3 loaded, trdy back", s, 16'h0040);

    // R11 queue behind a busy shifter, R4 reject when full
    sendWord(8'h3C, 1);
    busRd(2'd2, s); check("R11 holding while busy", s, 16'h0000);
    sendWord(8'hF0, 0);
    busRd(2'd2, s); check("R4 toe and err", s, 16'h0110);
    busRd(2'd2, s2); check("R9 read no side effect", s2, s);

    // R5 / R6 first word
    waitStatus(16'h0080, "R6 wait rrdy");
    check("R5 sclk rises", lastRises[15:0], 16'd8);
    check("R5 mosi msb first", {8'h0, lastMosi}, 16'h00A5);
    readRx();
    busRd(2'd2, s); check("R6 rrdy cleared", s & 16'h0080, 16'h0000);

    // R11 second word follows in order
    waitStatus(16'h0080, "R11 wait rrdy");
    check("R11 second mosi", {8'h0, lastMosi}, 16'h003C);
    readRx();
    waitStatus(16'h0060, "R11 idle");

    // R9 clear on write with arbitrary data
    busWr(2'd2, 16'h5A5A);
    busRd(2'd2, s); check("R9 cleared", s, 16'h0060);

    // R7 / R8 receive overrun
    sendWord(8'h11, 1);
    sendWord(8'h22, 1);
    waitStatus(16'h0008, "R7 wait roe");
    busRd(2'd2, s); check("R7 R8 overrun status", s, 16'h01E8);
    void'(expQ.pop_front());   // first word overwritten
    readRx();

    // R10 irq follows enabled status bits
    busWr(2'd3, 16'h0080);
    check("R10 rrdy enable only", {15'h0, irq}, 16'h0000);
    busWr(2'd3, 16'h0008);
    check("R10 roe enabled", {15'h0, irq}, 16'h0001);
    busWr(2'd2, 16'h0000);
    check("R10 R9 irq after clear", {15'h0, irq}, 16'h0000);
    check("R6 queue drained", expQ.size()[15:0], 16'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule